// File: doc/BRIEF.md
# Program Memory Access Protection Unit

This unit sits on the table-access path between a small processor and its on-chip program flash. Each access carries a target address, the program counter of the instruction that issued it, a direction (table read or table write), and a flag that says whether the external programming path is active. The unit classifies the target and the program counter into one of five regions: a boot region and four user regions. It then decides whether a write may reach the flash and whether read data may pass through. A refused read returns zero.

Three groups of per-region protection bits control the decision. Write-protect bits gate table writes. Read-protect bits limit table reads to code running in the same region. Code-protect bits apply only to the external programming path. The bits sit in six byte-wide configuration registers that share the table address space. A write can only clear these bits. Only an erase issued from the programming path can set them again.

The access path is combinational. There is no handshake: `acc_valid` marks a cycle that carries an access, and the results are valid in that same cycle. The flash is expected to present `flash_rdata` for `acc_addr` combinationally.

Top module: `pmem_guard`

## Requirements
- R1: Regions by address: 000000h–0007FFh is the boot region, 000800h–003FFFh is user region 0, 004000h–007FFFh is region 1, 008000h–00BFFFh is region 2, and 00C000h–00FFFFh is region 3. The same map is applied to the program counter.
- R2: Outside programming mode, a table write to a region whose write-protect bit is 0 leaves `flash_we` low. When the bit is 1, `flash_we` follows `acc_valid && acc_write`.
- R3: Outside programming mode, a table read of a region whose read-protect bit is 0 returns the flash data only if `exec_pc` lies in the same region. Otherwise `rd_data` is 00h.
- R4: When a region's read-protect bit is 1, table reads of that region return the flash data, whatever region `exec_pc` lies in.
- R5: Outside programming mode, code-protect bits have no effect on reads or writes.
- R6: In programming mode (`prog_mode`=1), only the code-protect bit governs a region. When it is 0, writes are blocked and reads return 00h. Write-protect and read-protect bits are ignored in this mode.
- R7: The configuration registers sit at 300008h+k, k=0..5. Group k/2 is selected by the offset: 0 is read-protect, 1 is write-protect, 2 is code-protect. An even k is the low byte: bits 3:0 are user regions 0–3 and bits 7:4 read 1. An odd k is the high byte: bit 0 is the boot region and bits 7:1 read 1. A table write ANDs the written data into the bits, so a bit can go from 1 to 0 but never from 0 to 1. The new value takes effect from the next cycle.
- R8: When `erase_req` and `erase_all` are both 1 and `prog_mode` is 1, every protection bit is set to 1. An erase request made while `prog_mode` is 0 has no effect.
- R9: When `erase_req`=1, `erase_all`=0 and `prog_mode`=1, all three bits of the region selected by `erase_sel` are set to 1 (0–3 select user regions, 4 selects the boot region). All other bits keep their values.
- R10: After reset, every protection bit is 1, and all six configuration registers read FFh.
- R11: A target address above 00FFFFh that is not a configuration address gets no protection: writes and reads pass through. A configuration address never raises `flash_we`, and a read of it returns the register contents.
- R12: `flash_we` and `rd_data` are combinational in the access cycle. With no valid access, `flash_we` is 0 and `rd_data` is 00h. A write access always gives `rd_data` 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_write | input | 1 | 1 = table write, 0 = table read |
| prog_mode | input | 1 | External programming path is active |
| acc_addr | input | 22 | Target address of the access |
| exec_pc | input | 22 | Program counter of the issuing instruction |
| wr_data | input | 8 | Data written by a table write |
| flash_rdata | input | 8 | Data presented by the flash for `acc_addr` |
| erase_req | input | 1 | Erase request (honoured only in programming mode) |
| erase_all | input | 1 | 1 = full erase, 0 = single-region erase |
| erase_sel | input | 3 | Region for a single-region erase |
| flash_we | output | 1 | Write enable passed to the flash |
| rd_data | output | 8 | Read result: flash data, register contents or zero |

## Verification
Both access results are combinational, so each one is checked in the same cycle it is driven. The bench drives at one ns after a rising edge and compares at the following falling edge. A configuration write or an erase changes the stored bits at the next rising edge. Its effect is therefore checked through a later access or through a register read in the next cycle, never in the cycle of the write itself. The bench's model of the bits is updated only after it has computed the expectation for the current access, which follows the same order.

// File: rtl/pmem_guard_pkg.sv
package pmem_guard_pkg;
  parameter int ADDR_W     = 22;
  parameter int DATA_W     = 8;
  parameter int NUM_USER   = 4;
  parameter int BLK_SHIFT  = 14;
  parameter int BOOT_TOP   = 'h7FF;
  parameter int CFG_BASE   = 'h300008;
  parameter int CFG_GROUPS = 3;

  localparam int NUM_BLK    = NUM_USER + 1;
  localparam int USER_SEL_W = $clog2(NUM_USER);
  localparam int CFG_REGS   = 2 * CFG_GROUPS;
  localparam int OFF_W      = $clog2(CFG_REGS);
  localparam int BIDX_W     = $clog2(NUM_BLK + 1);

  typedef logic [BIDX_W-1:0] blk_idx_t;
  localparam blk_idx_t BLK_BOOT = blk_idx_t'(NUM_USER);
  localparam blk_idx_t BLK_NONE = blk_idx_t'(NUM_USER + 1);

  // group order inside the configuration window
  localparam int GRP_RD = 0;
  localparam int GRP_WR = 1;
  localparam int GRP_CP = 2;

  typedef struct packed {
    logic [NUM_BLK-1:0] rd;
    logic [NUM_BLK-1:0] wr;
    logic [NUM_BLK-1:0] cp;
  } prot_bits_t;
endpackage

// File: rtl/pmg_blk_decode.sv
module pmg_blk_decode
  import pmem_guard_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  output blk_idx_t          blk
);
  localparam int HI = BLK_SHIFT + USER_SEL_W;

  always_comb begin
    if (addr[ADDR_W-1:HI] != '0)
      blk = BLK_NONE;
    else if (addr <= ADDR_W'(BOOT_TOP))
      blk = BLK_BOOT;
    else
      blk = BIDX_W'(addr[HI-1:BLK_SHIFT]);
  end
endmodule

// File: rtl/pmg_cfg_store.sv
module pmg_cfg_store
  import pmem_guard_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [OFF_W-1:0]  cfg_off,
  input  logic [DATA_W-1:0] cfg_wdata,
  input  logic              erase_go,
  input  logic              erase_all,
  input  logic [2:0]        erase_sel,
  output prot_bits_t        bits,
  output logic [DATA_W-1:0] cfg_rdata
);
  logic [NUM_BLK-1:0] grp_q [CFG_GROUPS];
  logic [NUM_BLK-1:0] set_mask;

  always_comb begin
    set_mask = '0;
    if (erase_all)
      set_mask = '1;
    else
      for (int i = 0; i < NUM_BLK; i++)
        if (erase_sel == 3'(i)) set_mask[i] = 1'b1;
  end

  for (genvar g = 0; g < CFG_GROUPS; g++) begin : g_grp
    logic [NUM_BLK-1:0] keep;
    always_comb begin
      keep = '1;
      if (cfg_wr && (cfg_off[OFF_W-1:1] == (OFF_W-1)'(g))) begin
        if (cfg_off[0]) keep[NUM_USER]     = cfg_wdata[0];
        else            keep[NUM_USER-1:0] = cfg_wdata[NUM_USER-1:0];
      end
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        grp_q[g] <= '1;
      else if (erase_go) grp_q[g] <= grp_q[g] | set_mask;
      else               grp_q[g] <= grp_q[g] & keep;
    end
  end

  assign bits.rd = grp_q[GRP_RD];
  assign bits.wr = grp_q[GRP_WR];
  assign bits.cp = grp_q[GRP_CP];

  logic [NUM_BLK-1:0] sel_grp;
  always_comb begin
    sel_grp = '1;
    for (int g = 0; g < CFG_GROUPS; g++)
      if (cfg_off[OFF_W-1:1] == (OFF_W-1)'(g)) sel_grp = grp_q[g];
    if (cfg_off[0])
      cfg_rdata = {{(DATA_W-1){1'b1}}, sel_grp[NUM_USER]};
    else
      cfg_rdata = {{(DATA_W-NUM_USER){1'b1}}, sel_grp[NUM_USER-1:0]};
  end
endmodule

// File: rtl/pmg_permit.sv
module pmg_permit
  import pmem_guard_pkg::*;
(
  input  blk_idx_t   tgt_blk,
  input  blk_idx_t   pc_blk,
  input  logic       prog_mode,
  input  prot_bits_t bits,
  output logic       wr_ok,
  output logic       rd_ok
);
  function automatic logic pick(input logic [NUM_BLK-1:0] v, input blk_idx_t idx);
    logic r;
    r = 1'b1;
    for (int i = 0; i < NUM_BLK; i++)
      if (idx == BIDX_W'(i)) r = v[i];
    return r;
  endfunction

  logic cp_bit, wr_bit, rd_bit, same_blk;

  always_comb begin
    cp_bit   = pick(bits.cp, tgt_blk);
    wr_bit   = pick(bits.wr, tgt_blk);
    rd_bit   = pick(bits.rd, tgt_blk);
    same_blk = (pc_blk == tgt_blk);
    if (prog_mode) begin
      wr_ok = cp_bit;
      rd_ok = cp_bit;
    end else begin
      wr_ok = wr_bit;
      rd_ok = rd_bit || same_blk;
    end
  end
endmodule

// File: rtl/pmem_guard.sv
module pmem_guard
  import pmem_guard_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic              prog_mode,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [ADDR_W-1:0] exec_pc,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [DATA_W-1:0] flash_rdata,
  input  logic              erase_req,
  input  logic              erase_all,
  input  logic [2:0]        erase_sel,
  output logic              flash_we,
  output logic [DATA_W-1:0] rd_data
);
  blk_idx_t          tgt_blk, pc_blk;
  prot_bits_t        bits;
  logic              wr_ok, rd_ok, is_cfg, cfg_wr;
  logic [ADDR_W-1:0] cfg_delta;
  logic [DATA_W-1:0] cfg_rdata;

  assign cfg_delta = acc_addr - ADDR_W'(CFG_BASE);
  assign is_cfg    = (acc_addr >= ADDR_W'(CFG_BASE)) && (cfg_delta < ADDR_W'(CFG_REGS));
  assign cfg_wr    = acc_valid && acc_write && is_cfg;

  pmg_blk_decode u_tgt_dec (.addr(acc_addr), .blk(tgt_blk));
  pmg_blk_decode u_pc_dec  (.addr(exec_pc),  .blk(pc_blk));

  pmg_cfg_store u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_wr    (cfg_wr),
    .cfg_off   (cfg_delta[OFF_W-1:0]),
    .cfg_wdata (wr_data),
    .erase_go  (erase_req && prog_mode),
    .erase_all (erase_all),
    .erase_sel (erase_sel),
    .bits      (bits),
    .cfg_rdata (cfg_rdata)
  );

  pmg_permit u_permit (
    .tgt_blk   (tgt_blk),
    .pc_blk    (pc_blk),
    .prog_mode (prog_mode),
    .bits      (bits),
    .wr_ok     (wr_ok),
    .rd_ok     (rd_ok)
  );

  assign flash_we = acc_valid && acc_write && !is_cfg && wr_ok;

  always_comb begin
    if (!acc_valid || acc_write) rd_data = '0;
    else if (is_cfg)             rd_data = cfg_rdata;
    else if (rd_ok)              rd_data = flash_rdata;
    else                         rd_data = '0;
  end
endmodule

// File: rtl/pmem_guard_chk.sv
module pmem_guard_chk
  import pmem_guard_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              acc_valid,
  input logic              acc_write,
  input logic              prog_mode,
  input logic [ADDR_W-1:0] acc_addr,
  input logic [ADDR_W-1:0] exec_pc,
  input logic              erase_req,
  input logic              flash_we,
  input logic [DATA_W-1:0] rd_data,
  input prot_bits_t        bits
);
  function automatic int region(input logic [ADDR_W-1:0] a);
    if (a > ADDR_W'('hFFFF)) return 5;
    if (a < ADDR_W'('h800))  return 4;
    if (a < ADDR_W'('h4000)) return 0;
    if (a < ADDR_W'('h8000)) return 1;
    if (a < ADDR_W'('hC000)) return 2;
    return 3;
  endfunction

  function automatic logic bit_at(input logic [NUM_BLK-1:0] v, input int r);
    return (r < NUM_BLK) ? v[r] : 1'b1;
  endfunction

  logic in_cfg;
  assign in_cfg = (acc_addr >= ADDR_W'(CFG_BASE)) && (acc_addr < ADDR_W'(CFG_BASE + CFG_REGS));

  AST_WP_BLOCKS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_write && !prog_mode && !bit_at(bits.wr, region(acc_addr))) |-> !flash_we); // R2

  AST_RP_ZERO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !acc_write && !prog_mode && !bit_at(bits.rd, region(acc_addr))
     && region(exec_pc) != region(acc_addr)) |-> (rd_data == '0)); // R3

  AST_CP_BLOCKS_EXT: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && prog_mode && !bit_at(bits.cp, region(acc_addr))) |-> (!flash_we && rd_data == '0)); // R6

  AST_CFG_NO_FLASH_WE: assert property (@(posedge clk) disable iff (!rst_n)
    in_cfg |-> !flash_we); // R11

  AST_BITS_ONE_WAY: assert property (@(posedge clk) disable iff (!rst_n)
    !(erase_req && prog_mode) |=> ((bits & ~$past(bits)) == '0)); // R7

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |-> (!flash_we && rd_data == '0)); // R12
endmodule

bind pmem_guard pmem_guard_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .acc_valid (acc_valid),
  .acc_write (acc_write),
  .prog_mode (prog_mode),
  .acc_addr  (acc_addr),
  .exec_pc   (exec_pc),
  .erase_req (erase_req),
  .flash_we  (flash_we),
  .rd_data   (rd_data),
  .bits      (bits)
);

// File: tb/pmem_guard_tb.sv
module pmem_guard_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [21:0] CFG0 = 22'h300008;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_valid = 1'b0, acc_write = 1'b0, prog_mode = 1'b0;
  logic [21:0] acc_addr = '0, exec_pc = '0;
  logic [7:0]  wr_data = '0, flash_rdata;
  logic        erase_req = 1'b0, erase_all = 1'b0;
  logic [2:0]  erase_sel = '0;
  logic        flash_we;
  logic [7:0]  rd_data;

  int total = 0, bad = 0;
  bit finished = 0;

  string      q_req[$];
  logic [8:0] q_exp[$];

  logic [4:0] m_rd = '1, m_wr = '1, m_cp = '1;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign flash_rdata = 8'h80 | {1'b0, acc_addr[6:0]};

  pmem_guard u_dut (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
    .prog_mode(prog_mode), .acc_addr(acc_addr), .exec_pc(exec_pc),
    .wr_data(wr_data), .flash_rdata(flash_rdata), .erase_req(erase_req),
    .erase_all(erase_all), .erase_sel(erase_sel), .flash_we(flash_we),
    .rd_data(rd_data)
  );

  function automatic int region(input logic [21:0] a);
    if (a > 22'h00FFFF) return 5;
    if (a <= 22'h0007FF) return 4;
    return int'(a / 22'h4000);
  endfunction

  function automatic logic [4:0] grp(input int g);
    return (g == 0) ? m_rd : (g == 1) ? m_wr : m_cp;
  endfunction

  function automatic logic [7:0] cfg_val(input int k);
    logic [4:0] v;
    v = grp(k / 2);
    return (k % 2 == 1) ? {7'h7F, v[4]} : {4'hF, v[3:0]};
  endfunction

  // scoreboard monitor: compare mid-cycle
  always @(negedge clk) begin
    if (q_exp.size() > 0) begin
      string      r;
      logic [8:0] e;
      r = q_req.pop_front();
      e = q_exp.pop_front();
      total++;
      if ({flash_we, rd_data} !== e) begin
        bad++;
        $display("FAIL %s: actual we=%0b rd=%02h expected we=%0b rd=%02h",
                 r, flash_we, rd_data, e[8], e[7:0]);
      end
    end
  end

  task automatic access(input string req, input logic wr, input logic ext,
                        input logic [21:0] a, input logic [21:0] pc, input logic [7:0] wd);
    logic we_e, ok;
    logic [7:0] rd_e;
    int b, k;
    bit cfg;
    @(posedge clk); #1;
    acc_valid = 1; acc_write = wr; prog_mode = ext; acc_addr = a; exec_pc = pc;
    wr_data = wd; erase_req = 0;
    cfg = (a >= CFG0) && (a < CFG0 + 22'd6);
    b = region(a);
    k = int'(a - CFG0);
    if (b == 5) ok = 1;
    else if (ext) ok = m_cp[b];
    else if (wr) ok = m_wr[b];
    else ok = m_rd[b] || (region(pc) == b);
    we_e = wr && !cfg && ok;
    rd_e = wr ? 8'h00 : cfg ? cfg_val(k) : ok ? (8'h80 | {1'b0, a[6:0]}) : 8'h00;
    q_req.push_back(req);
    q_exp.push_back({we_e, rd_e});
    if (wr && cfg) begin
      if (k % 2 == 1) begin
        if (k / 2 == 0) m_rd[4] &= wd[0];
        if (k / 2 == 1) m_wr[4] &= wd[0];
        if (k / 2 == 2) m_cp[4] &= wd[0];
      end else begin
        if (k / 2 == 0) m_rd[3:0] &= wd[3:0];
        if (k / 2 == 1) m_wr[3:0] &= wd[3:0];
        if (k / 2 == 2) m_cp[3:0] &= wd[3:0];
      end
    end
  endtask

  task automatic erase(input string req, input logic ext, input logic all, input logic [2:0] sel);
    @(posedge clk); #1;
    acc_valid = 0; acc_write = 0; prog_mode = ext;
    erase_req = 1; erase_all = all; erase_sel = sel;
    q_req.push_back(req);
    q_exp.push_back(9'h000);
    if (ext) begin
      if (all) begin m_rd = '1; m_wr = '1; m_cp = '1; end
      else begin m_rd[sel] = 1; m_wr[sel] = 1; m_cp[sel] = 1; end
    end
  endtask

  task automatic idle(input string req);
    @(posedge clk); #1;
    acc_valid = 0; acc_write = 0; erase_req = 0; prog_mode = 0;
    q_req.push_back(req);
    q_exp.push_back(9'h000);
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R10: reset state of every register, idle outputs (R12)
    idle("R12 idle after reset");
    for (int k = 0; k < 6; k++) access("R10 register reset value", 0, 0, CFG0 + 22'(k), 22'h0, 8'h00);
    // R1/R2: write-protect on region 2 with boundary addresses
    access("R2 write region 2 open", 1, 0, 22'h008000, 22'h0, 8'h11);
    access("R7 clear write bit of region 2", 1, 0, CFG0 + 22'd2, 22'h0, 8'hFB);
    access("R2 write region 2 blocked", 1, 0, 22'h008000, 22'h0, 8'h11);
    access("R2 write region 2 top blocked", 1, 0, 22'h00BFFF, 22'h0, 8'h11);
    access("R1 write 007FFF region 1 open", 1, 0, 22'h007FFF, 22'h0, 8'h11);
    access("R1 write 00C000 region 3 open", 1, 0, 22'h00C000, 22'h0, 8'h11);
    // R7: writing ones cannot set a cleared bit
    access("R7 try to set write bit", 1, 0, CFG0 + 22'd2, 22'h0, 8'hFF);
    access("R7 readback write group low", 0, 0, CFG0 + 22'd2, 22'h0, 8'h00);
    // R3: read protect on boot region
    access("R7 clear boot read bit", 1, 0, CFG0 + 22'd1, 22'h0, 8'hFE);
    access("R7 readback read group high", 0, 0, CFG0 + 22'd1, 22'h0, 8'h00);
    access("R3 boot read from boot pc", 0, 0, 22'h000100, 22'h0007FF, 8'h00);
    access("R3 boot read from region 0 pc", 0, 0, 22'h000100, 22'h000800, 8'h00);
    access("R3 boot read from region 3 pc", 0, 0, 22'h0007FF, 22'h00FFFE, 8'h00);
    // R4: open region read from elsewhere
    access("R4 region 0 read from region 3 pc", 0, 0, 22'h003FFF, 22'h00C010, 8'h00);
    access("R4 region 2 read from boot pc", 0, 0, 22'h008123, 22'h000010, 8'h00);
    // R5/R6: code protect on region 3
    access("R7 clear code bit region 3", 1, 0, CFG0 + 22'd4, 22'h0, 8'hF7);
    access("R5 normal write region 3 ignores code bit", 1, 0, 22'h00C100, 22'h0, 8'h22);
    access("R5 normal read region 3 ignores code bit", 0, 0, 22'h00C155, 22'h000000, 8'h00);
    access("R6 prog write region 3 blocked", 1, 1, 22'h00C100, 22'h0, 8'h22);
    access("R6 prog read region 3 zero", 0, 1, 22'h00C155, 22'h00C000, 8'h00);
    access("R6 prog write region 2 ignores write bit", 1, 1, 22'h008010, 22'h0, 8'h22);
    access("R6 prog read boot ignores read bit", 0, 1, 22'h000020, 22'h00C000, 8'h00);
    // R11: beyond user map and config space
    access("R11 write above map open", 1, 0, 22'h010000, 22'h0, 8'h33);
    access("R11 read above map open", 0, 0, 22'h200077, 22'h000900, 8'h00);
    access("R11 write next to config open", 1, 0, 22'h300007, 22'h0, 8'h33);
    access("R11 write config no flash we", 1, 0, CFG0 + 22'd5, 22'h0, 8'hFF);
    // R8: erase outside programming mode ignored
    erase("R8 erase without prog mode", 0, 1, 3'd0);
    access("R8 write group unchanged", 0, 0, CFG0 + 22'd2, 22'h0, 8'h00);
    access("R8 region 2 still blocked", 1, 0, 22'h008000, 22'h0, 8'h11);
    // R9: single-region erase
    access("R7 clear read bit region 1", 1, 0, CFG0 + 22'd0, 22'h0, 8'hFD);
    erase("R9 erase region 2", 1, 0, 3'd2);
    access("R9 write group low restored", 0, 0, CFG0 + 22'd2, 22'h0, 8'h00);
    access("R9 read group low kept", 0, 0, CFG0 + 22'd0, 22'h0, 8'h00);
    access("R9 boot read bit kept", 0, 0, CFG0 + 22'd1, 22'h0, 8'h00);
    access("R9 region 2 write reopened", 1, 0, 22'h008000, 22'h0, 8'h11);
    erase("R9 erase boot region", 1, 0, 3'd4);
    access("R9 boot read bit restored", 0, 0, CFG0 + 22'd1, 22'h0, 8'h00);
    // R8: full erase
    erase("R8 full erase", 1, 1, 3'd0);
    for (int k = 0; k < 6; k++) access("R8 register after full erase", 0, 0, CFG0 + 22'(k), 22'h0, 8'h00);
    access("R8 prog write region 3 reopened", 1, 1, 22'h00C100, 22'h0, 8'h22);
    idle("R12 idle at end");
    @(negedge clk); @(negedge clk);
    report();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      bad++;
      $display("FAIL R12 watchdog: actual=timeout expected=complete");
      report();
    end
  end
endmodule